// File: doc/BRIEF.md
# Misaligned Word Access Alignment Unit

This block sits between the address/data path of a 32-bit little-endian core and a single-cycle synchronous memory port. It receives a computed byte address, an operation code and store data. It always presents exactly one aligned word to memory, so an access can never straddle a page. On the way back it reshapes the fetched word for the destination register. A misaligned word load is not split into two accesses. It fetches the aligned word that contains the addressed byte and rotates it right, so that byte lands in the low lane. Word stores drop the low address bits. Block-transfer loads and stores also drop them, and block-transfer loads do no rotation.

An optional trap enable changes this. When it is set, any word-sized access (single or block transfer) with a nonzero byte offset becomes an abort. The abort reaches neither the memory nor the register file. Byte accesses never trap. The load result, or the abort indication, appears as a one-cycle pulse one cycle after the memory returns its read data. That is two clock edges after the request.

Top module: `legacy_align_lsu`

## Requirements
- R1: Whenever memory is enabled, mem_addr equals req_addr with its two least-significant bits forced to 0, and exactly one memory access is made per accepted request.
- R2: A word load (op 0) returns the aligned word rotated right by 8 × req_addr[1:0] bits.
- R3: A word store (op 2) writes all of req_wdata to the aligned word with mem_be = 4'b1111, whatever req_addr[1:0] is.
- R4: A byte load (op 1) returns the aligned word rotated right by 8 × req_addr[1:0], with bits [31:8] cleared.
- R5: A byte store (op 3) drives a one-hot mem_be selecting lane req_addr[1:0] and puts req_wdata[7:0] on that lane; the other bytes of the word are unchanged.
- R6: A block-transfer load (op 4) returns the aligned word without rotation. A block-transfer store (op 5) behaves as a word store.
- R7: With trap_en high, an op 0, 2, 4 or 5 request with req_addr[1:0] != 0 leaves mem_en low. It produces rsp_abort two cycles later with rsp_valid low, and memory contents are unchanged.
- R8: Byte accesses never trap. Word accesses are performed normally when trap_en is low or the offset is zero.
- R9: A load's rsp_valid is a one-cycle pulse two cycles after the request. Stores raise neither rsp_valid nor rsp_abort, and rsp_valid and rsp_abort are never high together.
- R10: During and right after reset, rsp_valid and rsp_abort are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_op | input | 3 | 0 word load, 1 byte load, 2 word store, 3 byte store, 4 block load, 5 block store |
| req_addr | input | 32 | Computed byte address |
| req_wdata | input | 32 | Store data |
| trap_en | input | 1 | Abort misaligned word accesses when high |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte lane write enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_en |
| rsp_valid | output | 1 | Load result valid pulse |
| rsp_abort | output | 1 | Alignment abort pulse |
| rsp_data | output | 32 | Shaped load result |

## Verification
Several properties are checked on every cycle: the alignment of the memory address, the full-word enables on word stores, one-hot lanes on byte stores, blocking of memory on trapped requests, the timing of the abort and load pulses, and the cleared upper bits of byte loads. The amount and direction of the rotation, the lack of rotation on block loads, and the fact that a trapped store or a byte store leaves other memory bytes intact cannot be seen from the control signals alone. The bench shows these by comparing read-back data against its own model of the memory.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    typedef enum logic [2:0] {
        OP_LDW = 3'd0,
        OP_LDB = 3'd1,
        OP_STW = 3'd2,
        OP_STB = 3'd3,
        OP_LDM = 3'd4,
        OP_STM = 3'd5
    } lsu_op_e;

    // Word-sized accesses are the ones subject to the alignment trap
    function automatic logic op_is_word(input logic [2:0] op);
        return (op == OP_LDW) || (op == OP_STW) || (op == OP_LDM) || (op == OP_STM);
    endfunction

    function automatic logic op_is_store(input logic [2:0] op);
        return (op == OP_STW) || (op == OP_STB) || (op == OP_STM);
    endfunction

    function automatic logic op_is_known(input logic [2:0] op);
        return op <= OP_STM;
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              trap_en,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              trap
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);

    logic [OFF_W-1:0] off;
    logic             misaligned;
    logic [BYTES-1:0] lane_sel;

    assign off        = req_addr[OFF_W-1:0];
    assign misaligned = (off != '0);

    assign trap     = req_valid && op_is_known(req_op) && trap_en
                    && op_is_word(req_op) && misaligned;
    assign mem_en   = req_valid && op_is_known(req_op) && !trap;
    assign mem_we   = mem_en && op_is_store(req_op);
    assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    generate
        for (genvar i = 0; i < BYTES; i++) begin : g_lane
            assign lane_sel[i] = (off == OFF_W'(i));
        end
    endgenerate

    assign mem_be    = (req_op == OP_STB) ? lane_sel : {BYTES{1'b1}};
    assign mem_wdata = (req_op == OP_STB) ? {BYTES{req_wdata[7:0]}} : req_wdata;

endmodule

// File: rtl/lsu_rotator.sv
module lsu_rotator #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]           din,
    input  logic [$clog2(DATA_W/8)-1:0] amt,
    output logic [DATA_W-1:0]           dout
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);

    // Right rotate by whole bytes: output lane i takes input lane (i + amt) mod BYTES
    generate
        for (genvar i = 0; i < BYTES; i++) begin : g_lane
            logic [OFF_W-1:0] src_idx;
            assign src_idx = OFF_W'(i) + amt;
            assign dout[i*8 +: 8] = din[{src_idx, 3'b000} +: 8];
        end
    endgenerate

endmodule

// File: rtl/lsu_load_shape.sv
module lsu_load_shape
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]                  op,
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  logic [DATA_W-1:0]           rdata,
    output logic [DATA_W-1:0]           result
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    logic [OFF_W-1:0]  rot_amt;
    logic [DATA_W-1:0] rotated;

    assign rot_amt = (op == OP_LDM) ? '0 : off;

    lsu_rotator #(.DATA_W(DATA_W)) u_rot (
        .din  (rdata),
        .amt  (rot_amt),
        .dout (rotated)
    );

    always_comb begin
        result = rotated;
        if (op == OP_LDB) begin
            result = {{(DATA_W-8){1'b0}}, rotated[7:0]};
        end
    end

endmodule

// File: rtl/legacy_align_lsu.sv
module legacy_align_lsu
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                trap_en,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                rsp_valid,
    output logic                rsp_abort,
    output logic [DATA_W-1:0]   rsp_data
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);

    typedef struct packed {
        logic              s1_load;
        logic [2:0]        s1_op;
        logic [OFF_W-1:0]  s1_off;
        logic              s1_abort;
        logic              out_valid;
        logic              out_abort;
        logic [DATA_W-1:0] out_data;
    } pipe_t;

    pipe_t             st_d, st_q;
    logic              trap;
    logic [DATA_W-1:0] shaped;

    lsu_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .trap_en   (trap_en),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .trap      (trap)
    );

    lsu_load_shape #(.DATA_W(DATA_W)) u_shape (
        .op     (st_q.s1_op),
        .off    (st_q.s1_off),
        .rdata  (mem_rdata),
        .result (shaped)
    );

    always_comb begin
        st_d           = st_q;
        // stage 1: remember what the outstanding read needs
        st_d.s1_load   = mem_en && !mem_we;
        st_d.s1_op     = req_op;
        st_d.s1_off    = req_addr[OFF_W-1:0];
        st_d.s1_abort  = trap;
        // stage 2: shape the returned word, or report the abort
        st_d.out_valid = st_q.s1_load;
        st_d.out_abort = st_q.s1_abort;
        if (st_q.s1_load) begin
            st_d.out_data = shaped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.out_valid;
    assign rsp_abort = st_q.out_abort;
    assign rsp_data  = st_q.out_data;

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [2:0]          req_op,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W-1:0]   req_wdata,
    input logic                trap_en,
    input logic                mem_en,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_be,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                rsp_valid,
    input logic                rsp_abort,
    input logic [DATA_W-1:0]   rsp_data
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    logic word_op, bad_align;
    assign word_op   = (req_op == OP_LDW) || (req_op == OP_STW)
                    || (req_op == OP_LDM) || (req_op == OP_STM);
    assign bad_align = req_valid && trap_en && word_op && (req_addr[OFF_W-1:0] != '0);

    // R1
    mem_addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr == {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}));

    // R3
    word_store_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && req_op == OP_STW) |-> (mem_be == '1 && mem_wdata == req_wdata));

    // R5
    byte_store_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && req_op == OP_STB) |-> ($countones(mem_be) == 1));

    // R4
    byte_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_LDB) |=> ##1 (rsp_valid && rsp_data[DATA_W-1:8] == '0));

    // R7
    trap_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_align |-> !mem_en);

    // R7
    trap_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_align |=> ##1 (rsp_abort && !rsp_valid));

    // R9
    load_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> ##1 rsp_valid);

    // R9
    rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_abort));

endmodule

bind legacy_align_lsu lsu_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .trap_en   (trap_en),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .rsp_valid (rsp_valid),
    .rsp_abort (rsp_abort),
    .rsp_data  (rsp_data)
);

// File: tb/legacy_align_lsu_bench.sv
module legacy_align_lsu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        trap_en = 1'b0;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata, rsp_data;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_abort;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    logic [31:0] mem_arr [16];
    logic [31:0] ref_mem [16];

    always #4 clk = ~clk;

    legacy_align_lsu u_legacy_align_lsu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .trap_en(trap_en),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_abort(rsp_abort), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] seed_word(input int i);
        return 32'h9E37_79B9 * (i + 1) ^ 32'h0BAD_F00D;
    endfunction

    // memory model: synchronous read/write on the DUT's port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem_arr[i] <= seed_word(i);
        end else if (mem_en) begin
            mem_rdata <= mem_arr[mem_addr[5:2]];
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem_arr[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end
        end
    end

    function automatic logic [31:0] rotr(input logic [31:0] w, input logic [1:0] off);
        logic [63:0] dbl;
        dbl = {w, w} >> (8 * off);
        return dbl[31:0];
    endfunction

    function automatic bit is_word(input logic [2:0] op);
        return op == 3'd0 || op == 3'd2 || op == 3'd4 || op == 3'd5;
    endfunction

    function automatic bit is_store(input logic [2:0] op);
        return op == 3'd2 || op == 3'd3 || op == 3'd5;
    endfunction

    function automatic logic [31:0] exp_load(input logic [2:0] op, input logic [31:0] w,
                                             input logic [1:0] off);
        case (op)
            3'd0:    return rotr(w, off);
            3'd1:    return {24'h0, rotr(w, off)[7:0]};
            default: return w;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic access(input logic [2:0] op, input logic [31:0] addr,
                          input logic [31:0] wd, input bit trap);
        logic [1:0]  off;
        logic [3:0]  idx;
        bit          trapped;
        logic [31:0] expw;
        off     = addr[1:0];
        idx     = addr[5:2];
        trapped = trap && is_word(op) && off != 2'd0;
        expw    = exp_load(op, ref_mem[idx], off);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; trap_en = trap;
        #1;
        check(mem_en == !trapped, trapped ? "R7 mem_en blocked" : "R8 mem_en", 32'(mem_en), 32'(!trapped));
        if (!trapped) begin
            check(mem_addr == {addr[31:2], 2'b00}, "R1 aligned address", mem_addr, {addr[31:2], 2'b00});
            if (op == 3'd2 || op == 3'd5) begin
                check(mem_be == 4'hF && mem_wdata == wd, "R3/R6 full word store", {mem_be, mem_wdata[27:0]}, {4'hF, wd[27:0]});
            end
            if (op == 3'd3) begin
                check(mem_be == (4'b0001 << off) && mem_wdata[off*8 +: 8] == wd[7:0],
                      "R5 byte store lane", {24'h0, mem_be, mem_wdata[off*8 +: 4]}, {24'h0, 4'b0001 << off, wd[3:0]});
            end
            if (is_store(op)) begin
                if (op == 3'd3) ref_mem[idx][off*8 +: 8] = wd[7:0];
                else            ref_mem[idx] = wd;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(!rsp_valid && !rsp_abort, "R9 no early response", {30'h0, rsp_valid, rsp_abort}, 32'h0);
        @(negedge clk);
        if (trapped) begin
            check(rsp_abort && !rsp_valid, "R7 abort pulse", {30'h0, rsp_valid, rsp_abort}, 32'h1);
        end else if (!is_store(op)) begin
            check(rsp_valid && !rsp_abort, "R9 load valid pulse", {30'h0, rsp_valid, rsp_abort}, 32'h2);
            check(rsp_data == expw, op == 3'd0 ? "R2 word load rotate" :
                  op == 3'd1 ? "R4 byte load" : "R6 block load no rotate", rsp_data, expw);
        end else begin
            check(!rsp_valid && !rsp_abort, "R9 store silent", {30'h0, rsp_valid, rsp_abort}, 32'h0);
        end
        @(negedge clk);
        check(!rsp_valid && !rsp_abort, "R9 single-cycle pulse", {30'h0, rsp_valid, rsp_abort}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) ref_mem[i] = seed_word(i);
        repeat (3) @(negedge clk);
        check(!rsp_valid && !rsp_abort, "R10 reset outputs", {30'h0, rsp_valid, rsp_abort}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && !rsp_abort, "R10 after reset", {30'h0, rsp_valid, rsp_abort}, 32'h0);

        // directed corners
        access(3'd2, 32'h0000_0003, 32'h4433_2211, 1'b0);          // R3 offset dropped
        for (int o = 0; o < 4; o++) access(3'd0, 32'h0000_0000 + o, 32'h0, 1'b0); // R2
        for (int o = 0; o < 4; o++) access(3'd1, 32'h0000_0000 + o, 32'h0, 1'b0); // R4
        for (int o = 0; o < 4; o++) access(3'd3, 32'h0000_0004 + o, 32'hA0 + o, 1'b0); // R5
        access(3'd0, 32'h0000_0006, 32'h0, 1'b0);
        access(3'd4, 32'h0000_0007, 32'h0, 1'b0);                   // R6
        access(3'd5, 32'h0000_000A, 32'hCAFE_BABE, 1'b0);           // R6
        access(3'd0, 32'h0000_0008, 32'h0, 1'b0);
        access(3'd0, 32'h0000_0001, 32'h0, 1'b1);                   // R7
        access(3'd2, 32'h0000_0003, 32'hDEAD_0000, 1'b1);           // R7 no write
        access(3'd0, 32'h0000_0000, 32'h0, 1'b1);                   // R7 word intact
        access(3'd4, 32'h0000_0002, 32'h0, 1'b1);                   // R7
        access(3'd1, 32'h0000_0002, 32'h0, 1'b1);                   // R8
        access(3'd3, 32'h0000_0001, 32'h5A, 1'b1);                  // R8
        access(3'd0, 32'h0000_0000, 32'h0, 1'b1);                   // R8 aligned

        // constrained random mix
        for (int k = 0; k < 400; k++) begin
            access(3'($urandom_range(0, 5)), $urandom(), $urandom(), 1'($urandom_range(0, 1)));
        end
        // read back every word to expose stray writes
        for (int i = 0; i < 16; i++) access(3'd4, 32'(i * 4), 32'h0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule